// File: doc/BRIEF.md
# Dual Split-Word PWM DAC

This block turns a 12-bit audio sample into two pulse-width-modulated logic outputs, so that a weighted resistor summing network followed by an external fourth-order low-pass filter can rebuild the analog waveform. The sample is cut into two 6-bit halves. The low half sets the pulse width on one pin and the high half sets it on the other. Both pins share one carrier frame, so the external network can weight the high-half pin 64 times more heavily than the low-half pin and add the two.

A frame is 200 clock cycles. With an 8 MHz clock this gives a 40 kHz carrier, five times an 8 kHz voice rate. A single 12-bit PWM would need a 4096-cycle frame to reach the same resolution. Each frame starts with a one-cycle strobe that asks the producer for the next sample. A sample presented with its valid strobe is held and applied to both pins together at the next frame boundary. If no sample arrives, the previous pulse widths repeat.

The resistor network and the analog filtering are built outside this block. Only the digital frame timing, the sample latching and the pulse generation are in it.

Top module: `split_pwm_dac`

## Requirements
- R1: While `rst` is high, `pwm_lo`, `pwm_hi` and `frame_start` are 0. After a reset both duty values are 0, so both pins stay low until a sample is accepted.
- R2: `frame_start` is high for exactly one cycle in every 200 (FRAME_LEN). The first pulse is in the first cycle after the first rising edge at which `rst` is low. That cycle is output cycle 0 of a frame, and the frame's cycles are numbered 0 to 199.
- R3: In each frame `pwm_lo` is high in output cycles 0 to d-1 and low in the rest, where d = `sample_in[5:0]` of the applied sample.
- R4: In each frame `pwm_hi` is high in output cycles 0 to d-1 and low in the rest, where d = `sample_in[11:6]` of the applied sample.
- R5: A sample whose `sample_vld` is high during output cycle j of a frame, with j from 0 to 197, applies to both pins from the next frame onward. If j is 198 or 199, it applies from the frame after the next one. The frame that is running never changes partway through.
- R6: In a frame with no `sample_vld`, the following frame repeats the previous pulse widths on both pins.
- R7: If `sample_vld` is high in more than one cycle of a frame, only the last of those samples is applied.
- R8: Code 0 on a half keeps its pin low for the whole frame. Code 63 keeps it high for exactly 63 cycles, so a pin is never high for a whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one PWM tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 12 | Sample word: bits 5:0 set the low-half width, bits 11:6 set the high-half width |
| sample_vld | input | 1 | Valid strobe for `sample_in`, sampled on each rising edge |
| pwm_lo | output | 1 | Registered PWM output for the low six bits |
| pwm_hi | output | 1 | Registered PWM output for the high six bits |
| frame_start | output | 1 | Registered one-cycle pulse in output cycle 0 of each frame |

## Verification
Every output is registered from the frame counter, so all three pins show frame position p in the same cycle, one edge after the counter holds p. The bench locks on to `frame_start` at a falling edge and then samples all pins at each of the next 200 falling edges. It compares each sample with the expected level for that position. A strobe driven at a falling edge is taken at the next rising edge, so the bench places strobes by output-cycle number. This lets it check the 197/198 boundary of R5 exactly: a strobe in cycle 197 shows in the very next frame, and a strobe in cycle 198 or 199 shows only one frame later.

// File: rtl/split_pwm_pkg.sv
package split_pwm_pkg;
  // Number of PWM slices a sample word is divided into.
  localparam int unsigned NUM_SLICES = 2;
  // Default slice width and carrier frame length in clock ticks.
  localparam int unsigned DEF_SLICE_W = 6;
  localparam int unsigned DEF_FRAME_LEN = 200;

  // Slice indices: which pin each part of the word drives.
  typedef enum int unsigned {
    SLICE_LOW  = 0,
    SLICE_HIGH = 1
  } slice_idx_e;
endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int unsigned FRAME_LEN = 200,
  parameter int unsigned CNT_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] pos,
  output logic             at_first,
  output logic             at_last
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);

  assign at_first = (pos == '0);
  assign at_last  = (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (at_last) begin
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/word_staging.sv
module word_staging #(
  parameter int unsigned WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_vld,
  input  logic              commit,
  output logic [WORD_W-1:0] active_word
);
  logic [WORD_W-1:0] staged_word;

  // The last accepted word waits here. It is copied to the active register
  // only at the frame boundary, so a word that is never replaced repeats.
  always_ff @(posedge clk) begin
    if (rst) begin
      staged_word <= '0;
    end else if (word_vld) begin
      staged_word <= word_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_word <= '0;
    end else if (commit) begin
      active_word <= staged_word;
    end
  end
endmodule

// File: rtl/pwm_slice.sv
module pwm_slice #(
  parameter int unsigned DUTY_W = 6,
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  pos,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_q
);
  localparam int unsigned CMP_W = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

  logic [CMP_W-1:0] pos_ext;
  logic [CMP_W-1:0] duty_ext;

  assign pos_ext  = CMP_W'(pos);
  assign duty_ext = CMP_W'(duty);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= (pos_ext < duty_ext);
    end
  end
endmodule

// File: rtl/split_pwm_dac.sv
module split_pwm_dac #(
  parameter int unsigned SLICE_W = split_pwm_pkg::DEF_SLICE_W,
  parameter int unsigned FRAME_LEN = split_pwm_pkg::DEF_FRAME_LEN
) (
  input  logic                                       clk,
  input  logic                                       rst,
  input  logic [split_pwm_pkg::NUM_SLICES*SLICE_W-1:0] sample_in,
  input  logic                                       sample_vld,
  output logic                                       pwm_lo,
  output logic                                       pwm_hi,
  output logic                                       frame_start
);
  import split_pwm_pkg::*;

  localparam int unsigned WORD_W = NUM_SLICES * SLICE_W;
  localparam int unsigned CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0]  pos;
  logic              at_first;
  logic              at_last;
  logic [WORD_W-1:0] active_word;
  logic [NUM_SLICES-1:0] pwm_vec;

  frame_timer #(
    .FRAME_LEN(FRAME_LEN),
    .CNT_W(CNT_W)
  ) u_timer (
    .clk(clk),
    .rst(rst),
    .pos(pos),
    .at_first(at_first),
    .at_last(at_last)
  );

  word_staging #(
    .WORD_W(WORD_W)
  ) u_staging (
    .clk(clk),
    .rst(rst),
    .word_in(sample_in),
    .word_vld(sample_vld),
    .commit(at_last),
    .active_word(active_word)
  );

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    pwm_slice #(
      .DUTY_W(SLICE_W),
      .CNT_W(CNT_W)
    ) u_slice (
      .clk(clk),
      .rst(rst),
      .pos(pos),
      .duty(active_word[s*SLICE_W +: SLICE_W]),
      .pwm_q(pwm_vec[s])
    );
  end

  // Registered beside the slices so all three pins line up on one position.
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_start <= 1'b0;
    end else begin
      frame_start <= at_first;
    end
  end

  assign pwm_lo = pwm_vec[SLICE_LOW];
  assign pwm_hi = pwm_vec[SLICE_HIGH];
endmodule

// File: rtl/split_pwm_dac_chk.sv
module split_pwm_dac_chk #(
  parameter int unsigned SLICE_W = 6,
  parameter int unsigned FRAME_LEN = 200
) (
  input logic clk,
  input logic rst,
  input logic pwm_lo,
  input logic pwm_hi,
  input logic frame_start
);
  localparam int unsigned MAX_HIGH = (1 << SLICE_W) - 1;

  logic        rst_q;
  logic        seen_start;
  int unsigned gap;
  int unsigned run_lo;
  int unsigned run_hi;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      seen_start <= 1'b0;
      gap <= 0;
      run_lo <= 0;
      run_hi <= 0;
    end else begin
      if (frame_start) begin
        seen_start <= 1'b1;
        gap <= 1;
      end else if (gap < FRAME_LEN + 1) begin
        gap <= gap + 1;
      end
      run_lo <= pwm_lo ? run_lo + 1 : 0;
      run_hi <= pwm_hi ? run_hi + 1 : 0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      AST_RESET_QUIET: assert (!pwm_lo && !pwm_hi && !frame_start); // R1
    end
    if (!rst && seen_start && frame_start) begin
      AST_FRAME_PERIOD: assert (gap == FRAME_LEN); // R2
    end
    if (!rst && seen_start) begin
      AST_FRAME_NOT_LATE: assert (gap <= FRAME_LEN); // R2
      AST_LO_RUN_LIMIT: assert (run_lo <= MAX_HIGH); // R8
      AST_HI_RUN_LIMIT: assert (run_hi <= MAX_HIGH); // R8
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start); // R2

  AST_LO_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_lo) |-> frame_start); // R3

  AST_HI_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_hi) |-> frame_start); // R4
endmodule

bind split_pwm_dac split_pwm_dac_chk #(
  .SLICE_W(SLICE_W),
  .FRAME_LEN(FRAME_LEN)
) u_chk (
  .clk(clk),
  .rst(rst),
  .pwm_lo(pwm_lo),
  .pwm_hi(pwm_hi),
  .frame_start(frame_start)
);

// File: tb/test_split_pwm_dac.sv
module test_split_pwm_dac;
  localparam int FRAME = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] sample_in = '0;
  logic        sample_vld = 1'b0;
  logic        pwm_lo;
  logic        pwm_hi;
  logic        frame_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  split_pwm_dac i_split_pwm_dac (
    .clk(clk),
    .rst(rst),
    .sample_in(sample_in),
    .sample_vld(sample_vld),
    .pwm_lo(pwm_lo),
    .pwm_hi(pwm_hi),
    .frame_start(frame_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Move to the falling edge in output cycle 0 of the next frame.
  task automatic wait_frame();
    int n = 0;
    do begin
      @(negedge clk);
      sample_vld = 1'b0;
      n++;
    end while (!frame_start && n < 3 * FRAME);
  endtask

  // One frame: strobes at output cycles p1 and p2 (-1 for none), and checks
  // of the pulse shape on both pins and of the frame_start pattern.
  task automatic run_frame(input int p1, input logic [11:0] v1,
                           input int p2, input logic [11:0] v2,
                           input int elo, input int ehi, input string tag);
    int bad_lo = 0, bad_hi = 0, bad_fs = 0, cnt_lo = 0, cnt_hi = 0;
    wait_frame();
    for (int i = 0; i < FRAME; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm_lo) cnt_lo++;
      if (pwm_hi) cnt_hi++;
      if (pwm_lo !== (i < elo)) bad_lo++;
      if (pwm_hi !== (i < ehi)) bad_hi++;
      if (frame_start !== (i == 0)) bad_fs++;
      if (i == p1) begin
        sample_in = v1;
        sample_vld = 1'b1;
      end else if (i == p2) begin
        sample_in = v2;
        sample_vld = 1'b1;
      end else begin
        sample_vld = 1'b0;
      end
    end
    check(bad_lo == 0, {"R3 pwm_lo high count ", tag}, cnt_lo, elo);
    check(bad_hi == 0, {"R4 pwm_hi high count ", tag}, cnt_hi, ehi);
    check(bad_fs == 0, {"R2 frame_start misplaced cycles ", tag}, bad_fs, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    sample_vld = 1'b0;
    repeat (5) @(negedge clk);
    check(!pwm_lo && !pwm_hi && !frame_start, "R1 outputs low in reset",
          {pwm_lo, pwm_hi, frame_start}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(frame_start === 1'b1, "R2 first frame_start after release", frame_start, 1);
    check(!pwm_lo && !pwm_hi, "R1 zero duty after reset", {pwm_lo, pwm_hi}, 0);
  endtask

  task automatic t_basic();
    // Strobe mid-frame; the running frame keeps zero duty (R5).
    run_frame(50, 12'hABC, -1, '0, 0, 0, "r5_running_frame");
    run_frame(-1, '0, -1, '0, 60, 42, "R3/R4 0xABC");
  endtask

  task automatic t_hold();
    run_frame(-1, '0, -1, '0, 60, 42, "R6 hold 1");
    run_frame(-1, '0, -1, '0, 60, 42, "R6 hold 2");
  endtask

  task automatic t_extremes();
    run_frame(3, 12'hFFF, -1, '0, 60, 42, "R8 pre");
    run_frame(0, 12'h000, -1, '0, 63, 63, "R8 full code");
    run_frame(-1, '0, -1, '0, 0, 0, "R8 zero code");
  endtask

  task automatic t_slices();
    run_frame(7, 12'h03F, -1, '0, 0, 0, "R3 pre");
    run_frame(7, 12'hFC0, -1, '0, 63, 0, "R3 low slice only");
    run_frame(7, 12'h001, -1, '0, 0, 63, "R4 high slice only");
    run_frame(7, 12'h040, -1, '0, 1, 0, "R3 lsb");
    run_frame(-1, '0, -1, '0, 0, 1, "R4 lsb");
  endtask

  task automatic t_late();
    // Current duty lo=0 hi=1.
    run_frame(197, 12'h105, -1, '0, 0, 1, "R5 cycle 197 strobe");
    run_frame(198, 12'h20A, -1, '0, 5, 4, "R5 applied after 197");
    run_frame(-1, '0, -1, '0, 5, 4, "R5 cycle 198 not yet");
    run_frame(199, 12'h30F, -1, '0, 10, 8, "R5 applied after 198");
    run_frame(-1, '0, -1, '0, 10, 8, "R5 cycle 199 not yet");
    run_frame(-1, '0, -1, '0, 15, 12, "R5 applied after 199");
  endtask

  task automatic t_last_wins();
    run_frame(10, 12'h111, 20, 12'h2C7, 15, 12, "R7 pre");
    run_frame(-1, '0, -1, '0, 7, 11, "R7 last strobe wins");
  endtask

  task automatic t_reset_mid();
    run_frame(30, 12'hFFF, -1, '0, 7, 11, "R1 pre");
    wait_frame();
    repeat (10) @(negedge clk);
    check(pwm_lo && pwm_hi, "R1 duty loaded before reset", {pwm_lo, pwm_hi}, 3);
    t_reset();
    run_frame(-1, '0, -1, '0, 0, 0, "R1 duty cleared");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hold();
    t_extremes();
    t_slices();
    t_late();
    t_last_wins();
    t_reset_mid();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule